// File: doc/BRIEF.md
# Shared-Resource Multi-Function Target Address Decoder

This block sits behind the target side of a bus interface for a device that shows up to three logical functions to the host. All of them front one internal register file and two internal memories, a 24-bit-wide one and a 16-bit-wide one. Each function owns four base address registers (BARs) and two command enables, one for memory space and one for I/O space. Every incoming transaction address is compared with the windows of every live function. A hit is gated by the matching enable and turned into a target select and an offset inside that target.

After reset the decoder sits in state ST_BOOT. In that state it ignores configuration writes and claims nothing. A pulse on `boot_done` samples the boot-time function mask and takes the decoder to ST_ACTIVE, which it never leaves. This ST_BOOT to ST_ACTIVE step is the only transition. The number of set bits in the mask decides how many functions exist, and the survivors always take the lowest function numbers. BAR and command contents are written and read through a small configuration port. Decode results appear on registered outputs one clock after the request.

Top module: `mfd_decode_top`

## Requirements
- R1: After reset the decoder is in ST_BOOT, `hit_valid` is 0, and every BAR and command register reads back as 0 on `cfg_rdata`.
- R2: Configuration selects are 0 to 3 for BAR1 to BAR4 and 4 for the command register. A BAR keeps only the address bits at or above its window size: BAR1 is 1024 bytes, BAR2 is 16384, BAR3 is 8192 and BAR4 is 2048, and the lower bits read as 0. The command register keeps bit 0 (I/O enable) and bit 1 (memory enable) and reads 0 in all other bits.
- R3: A memory request (`req_io`=0) inside a function's BAR1 is claimed with target code 1 (registers), and the offset is the address bits below the window size.
- R4: A memory request inside BAR2 is claimed with target code 2 (24-bit memory). One inside BAR3 is claimed with target code 3 (16-bit memory). In both cases the offset is the address bits below the window size, and an address one byte past a window is not claimed.
- R5: A memory request is claimed only if that function's memory enable is 1. An I/O request is claimed only if that function's I/O enable is 1.
- R6: An I/O request (`req_io`=1) inside BAR4 is claimed. Address bit 10 equal to 0 gives target code 1. Bit 10 equal to 1 gives target code 2. The offset is address bits 9:0.
- R7: I/O requests never match BAR1 to BAR3, and memory requests never match BAR4.
- R8: A BAR whose value is 0 never produces a hit.
- R9: In ST_BOOT, configuration writes are ignored and no request is claimed. On `boot_done`, N = the number of ones in `boot_mask`, and functions 0 to N-1 become live. Configuration writes to any other function are ignored, reads from it return 0, and it never hits. Later `boot_done` pulses have no effect.
- R10: When windows overlap, the lowest-numbered live function wins. Inside one function the lowest-numbered BAR wins. `hit_func` reports the winning function.
- R11: The results are registered and appear one clock after the request. With no request, or with no claim, `hit_valid`, `hit_target` and `hit_offset` are all 0 on the next clock.
- R12: The same resource location reached through different functions' windows gives the same target code and offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boot_done | input | 1 | Pulse that samples `boot_mask` and leaves ST_BOOT |
| boot_mask | input | NF | Boot-time function presence mask; only its count of ones matters |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_func | input | FW | Function addressed by the configuration port |
| cfg_sel | input | 3 | 0 to 3 select BAR1 to BAR4, 4 selects the command register |
| cfg_wdata | input | AW | Configuration write data |
| cfg_rdata | output | AW | Combinational read data for `cfg_func`/`cfg_sel` |
| req_valid | input | 1 | A transaction address is presented |
| req_io | input | 1 | 1 for an I/O-space request, 0 for a memory-space request |
| req_addr | input | AW | Transaction address |
| hit_valid | output | 1 | Registered claim flag |
| hit_func | output | FW | Winning function number |
| hit_target | output | 2 | 0 none, 1 registers, 2 24-bit memory, 3 16-bit memory |
| hit_offset | output | AW | Offset inside the selected target |

## Verification
Decode results are due exactly one clock after the request is presented. Configuration read data is combinational and is due in the same cycle as the select, reflecting every write captured at an earlier edge. The bench drives inputs on the falling edge and keeps a behavioural model that is updated at each rising edge from the inputs as they stood before the update. Every output field is compared with the model at the next falling edge, which is the first point at which the registered result is visible. Directed checks take the same one-clock sample point for decode results and read `cfg_rdata` shortly after its select is applied.

// File: rtl/mfd_pkg.sv
package mfd_pkg;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_REG  = 2'd1,
        TGT_M24  = 2'd2,
        TGT_M16  = 2'd3
    } tgt_e;

    typedef enum logic {
        ST_BOOT   = 1'b0,
        ST_ACTIVE = 1'b1
    } dec_state_e;

    localparam int unsigned NUM_BARS = 4;
    localparam int unsigned SEL_W    = 3;
    localparam logic [SEL_W-1:0] SEL_CMD = 3'd4;

endpackage

// File: rtl/mfd_bar_bank.sv
module mfd_bar_bank
    import mfd_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter logic [NUM_BARS-1:0][AW-1:0] KEEP = '0
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [SEL_W-1:0]              wr_sel,
    input  logic [AW-1:0]                 wr_data,
    output logic [NUM_BARS-1:0][AW-1:0]   bar_q,
    output logic                          mem_en_q,
    output logic                          io_en_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bar_q    <= '0;
            mem_en_q <= 1'b0;
            io_en_q  <= 1'b0;
        end else if (wr_en) begin
            for (int b = 0; b < NUM_BARS; b++) begin
                if (wr_sel == SEL_W'(b)) begin
                    bar_q[b] <= wr_data & KEEP[b];
                end
            end
            if (wr_sel == SEL_CMD) begin
                io_en_q  <= wr_data[0];
                mem_en_q <= wr_data[1];
            end
        end
    end

    // R2: register contents move only on a write strobe
    p_bar_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(bar_q) && $stable(mem_en_q) && $stable(io_en_q)));

endmodule

// File: rtl/mfd_win_match.sv
module mfd_win_match
    import mfd_pkg::*;
#(
    parameter int unsigned AW       = 32,
    parameter int unsigned IO_BYTES = 2048,
    parameter logic [NUM_BARS-1:0][AW-1:0] KEEP = '0
) (
    input  logic                        live,
    input  logic                        req_io,
    input  logic [AW-1:0]               req_addr,
    input  logic [NUM_BARS-1:0][AW-1:0] bar_q,
    input  logic                        mem_en,
    input  logic                        io_en,
    output logic                        hit,
    output logic [1:0]                  tgt,
    output logic [AW-1:0]               off
);

    localparam logic [AW-1:0] HALF_BIT  = AW'(IO_BYTES / 2);
    localparam logic [AW-1:0] HALF_MASK = AW'(IO_BYTES / 2) - AW'(1);
    localparam int unsigned   NUM_MEM   = NUM_BARS - 1;

    logic [NUM_MEM-1:0] mem_hit;
    logic               io_hit;

    genvar gb;
    generate
        for (gb = 0; gb < NUM_MEM; gb++) begin : g_mem_win
            assign mem_hit[gb] = live && !req_io && mem_en &&
                                 (bar_q[gb] != '0) &&
                                 ((req_addr & KEEP[gb]) == bar_q[gb]);
        end
    endgenerate

    assign io_hit = live && req_io && io_en &&
                    (bar_q[NUM_BARS-1] != '0) &&
                    ((req_addr & KEEP[NUM_BARS-1]) == bar_q[NUM_BARS-1]);

    always_comb begin
        hit = 1'b0;
        tgt = TGT_NONE;
        off = '0;
        if (mem_hit[0]) begin
            hit = 1'b1;
            tgt = TGT_REG;
            off = req_addr & ~KEEP[0];
        end else if (mem_hit[1]) begin
            hit = 1'b1;
            tgt = TGT_M24;
            off = req_addr & ~KEEP[1];
        end else if (mem_hit[2]) begin
            hit = 1'b1;
            tgt = TGT_M16;
            off = req_addr & ~KEEP[2];
        end else if (io_hit) begin
            hit = 1'b1;
            tgt = ((req_addr & HALF_BIT) != '0) ? TGT_M24 : TGT_REG;
            off = req_addr & HALF_MASK;
        end
    end

    // R7: memory-window and I/O-window matches never coexist
    always_comb begin
        p_space_split_r7: assert (!(io_hit && (mem_hit != '0)));
    end

endmodule

// File: rtl/mfd_prio_pick.sv
module mfd_prio_pick
    import mfd_pkg::*;
#(
    parameter int unsigned NF = 3,
    parameter int unsigned AW = 32,
    parameter int unsigned FW = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NF-1:0]          fn_hit,
    input  logic [NF-1:0][1:0]     fn_tgt,
    input  logic [NF-1:0][AW-1:0]  fn_off,
    output logic                   win_any,
    output logic [FW-1:0]          win_func,
    output logic [1:0]             win_tgt,
    output logic [AW-1:0]          win_off
);

    logic [NF-1:0] grant;

    always_comb begin
        grant    = '0;
        win_any  = 1'b0;
        win_func = '0;
        win_tgt  = TGT_NONE;
        win_off  = '0;
        for (int i = 0; i < NF; i++) begin
            if (fn_hit[i] && !win_any) begin
                grant[i] = 1'b1;
                win_any  = 1'b1;
                win_func = FW'(i);
                win_tgt  = fn_tgt[i];
                win_off  = fn_off[i];
            end
        end
    end

    // R10: a single winner per transaction
    p_one_winner_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    genvar gi;
    generate
        for (gi = 1; gi < NF; gi++) begin : g_low_check
            // R10: a granted function has no lower-numbered contender
            p_lowest_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
                grant[gi] |-> (fn_hit[gi-1:0] == '0));
        end
    endgenerate

endmodule

// File: rtl/mfd_decode_top.sv
module mfd_decode_top
    import mfd_pkg::*;
#(
    parameter int unsigned NF        = 3,
    parameter int unsigned AW        = 32,
    parameter int unsigned REG_BYTES = 1024,
    parameter int unsigned M24_BYTES = 16384,
    parameter int unsigned M16_BYTES = 8192,
    parameter int unsigned IO_BYTES  = 2048,
    parameter int unsigned FW        = (NF > 1) ? $clog2(NF) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_done,
    input  logic [NF-1:0]     boot_mask,
    input  logic              cfg_wr,
    input  logic [FW-1:0]     cfg_func,
    input  logic [2:0]        cfg_sel,
    input  logic [AW-1:0]     cfg_wdata,
    output logic [AW-1:0]     cfg_rdata,
    input  logic              req_valid,
    input  logic              req_io,
    input  logic [AW-1:0]     req_addr,
    output logic              hit_valid,
    output logic [FW-1:0]     hit_func,
    output logic [1:0]        hit_target,
    output logic [AW-1:0]     hit_offset
);

    localparam int unsigned CW = $clog2(NF + 1);

    function automatic logic [NUM_BARS-1:0][AW-1:0] build_keep();
        logic [NUM_BARS-1:0][AW-1:0] k;
        k[0] = ~(AW'(REG_BYTES) - AW'(1));
        k[1] = ~(AW'(M24_BYTES) - AW'(1));
        k[2] = ~(AW'(M16_BYTES) - AW'(1));
        k[3] = ~(AW'(IO_BYTES)  - AW'(1));
        return k;
    endfunction

    localparam logic [NUM_BARS-1:0][AW-1:0] KEEP = build_keep();

    dec_state_e state_q, state_d;
    logic [NF-1:0] live_q;
    logic [CW-1:0] boot_cnt;

    logic [NF-1:0]                       fn_hit;
    logic [NF-1:0][1:0]                  fn_tgt;
    logic [NF-1:0][AW-1:0]               fn_off;
    logic [NF-1:0][NUM_BARS-1:0][AW-1:0] fn_bar;
    logic [NF-1:0]                       fn_mem_en;
    logic [NF-1:0]                       fn_io_en;

    logic              win_any;
    logic [FW-1:0]     win_func;
    logic [1:0]        win_tgt;
    logic [AW-1:0]     win_off;

    // state transition
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT:   if (boot_done) state_d = ST_ACTIVE;
            ST_ACTIVE: state_d = ST_ACTIVE;
            default:   state_d = ST_BOOT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_BOOT;
        else        state_q <= state_d;
    end

    // count surviving functions at boot
    always_comb begin
        boot_cnt = '0;
        for (int f = 0; f < NF; f++) begin
            boot_cnt = boot_cnt + CW'(boot_mask[f]);
        end
    end

    // pack survivors onto the lowest function numbers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q <= '0;
        end else if (state_q == ST_BOOT && boot_done) begin
            for (int f = 0; f < NF; f++) begin
                live_q[f] <= (CW'(f) < boot_cnt);
            end
        end
    end

    genvar gf;
    generate
        for (gf = 0; gf < NF; gf++) begin : g_func
            logic wr_this;
            logic live_this;

            assign live_this = live_q[gf] && (state_q == ST_ACTIVE);
            assign wr_this   = cfg_wr && live_this && (cfg_func == FW'(gf));

            mfd_bar_bank #(
                .AW   (AW),
                .KEEP (KEEP)
            ) u_bank (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_en    (wr_this),
                .wr_sel   (cfg_sel),
                .wr_data  (cfg_wdata),
                .bar_q    (fn_bar[gf]),
                .mem_en_q (fn_mem_en[gf]),
                .io_en_q  (fn_io_en[gf])
            );

            mfd_win_match #(
                .AW       (AW),
                .IO_BYTES (IO_BYTES),
                .KEEP     (KEEP)
            ) u_match (
                .live     (live_this),
                .req_io   (req_io),
                .req_addr (req_addr),
                .bar_q    (fn_bar[gf]),
                .mem_en   (fn_mem_en[gf]),
                .io_en    (fn_io_en[gf]),
                .hit      (fn_hit[gf]),
                .tgt      (fn_tgt[gf]),
                .off      (fn_off[gf])
            );
        end
    endgenerate

    mfd_prio_pick #(
        .NF (NF),
        .AW (AW),
        .FW (FW)
    ) u_pick (
        .clk      (clk),
        .rst_n    (rst_n),
        .fn_hit   (fn_hit),
        .fn_tgt   (fn_tgt),
        .fn_off   (fn_off),
        .win_any  (win_any),
        .win_func (win_func),
        .win_tgt  (win_tgt),
        .win_off  (win_off)
    );

    // configuration read-back
    always_comb begin
        cfg_rdata = '0;
        for (int f = 0; f < NF; f++) begin
            if (live_q[f] && cfg_func == FW'(f)) begin
                if (cfg_sel < SEL_CMD) begin
                    cfg_rdata = fn_bar[f][cfg_sel[1:0]];
                end else if (cfg_sel == SEL_CMD) begin
                    cfg_rdata = {{(AW-2){1'b0}}, fn_mem_en[f], fn_io_en[f]};
                end
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_valid  <= 1'b0;
            hit_func   <= '0;
            hit_target <= TGT_NONE;
            hit_offset <= '0;
        end else if (req_valid && state_q == ST_ACTIVE && win_any) begin
            hit_valid  <= 1'b1;
            hit_func   <= win_func;
            hit_target <= win_tgt;
            hit_offset <= win_off;
        end else begin
            hit_valid  <= 1'b0;
            hit_func   <= '0;
            hit_target <= TGT_NONE;
            hit_offset <= '0;
        end
    end

    // R11: no request, no claim on the following clock
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !hit_valid);

    // R9: nothing is claimed while booting
    p_boot_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BOOT) |=> !hit_valid);

    // R9: once active, the decoder stays active
    p_state_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACTIVE) |=> (state_q == ST_ACTIVE));

    // R9: a reported function is always a live one
    p_func_live_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid |-> ((32'(hit_func) < NF) && live_q[hit_func]));

    // R9: the live set stays frozen after boot
    p_live_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACTIVE) |=> $stable(live_q));

endmodule

// File: tb/sim_mfd_decode_top.sv
`timescale 1ns/1ps
module sim_mfd_decode_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boot_done = 1'b0;
    logic [2:0]  boot_mask = '0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_func = '0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic        req_io = 1'b0;
    logic [31:0] req_addr = '0;
    logic        hit_valid;
    logic [1:0]  hit_func;
    logic [1:0]  hit_target;
    logic [31:0] hit_offset;

    mfd_decode_top u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .boot_done  (boot_done),
        .boot_mask  (boot_mask),
        .cfg_wr     (cfg_wr),
        .cfg_func   (cfg_func),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .req_valid  (req_valid),
        .req_io     (req_io),
        .req_addr   (req_addr),
        .hit_valid  (hit_valid),
        .hit_func   (hit_func),
        .hit_target (hit_target),
        .hit_offset (hit_offset)
    );

    always #4 clk = ~clk;

    int    n_run = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // behavioural reference model
    int unsigned win_sz [4] = '{1024, 16384, 8192, 2048};
    logic [31:0] m_bar [3][4];
    logic [1:0]  m_cmd [3];
    int          m_live;
    bit          m_active;
    logic        e_v;
    logic [1:0]  e_f, e_t;
    logic [31:0] e_o;

    function automatic logic [31:0] keep_of(int b);
        return ~(32'(win_sz[b]) - 32'd1);
    endfunction

    always @(posedge clk) begin : model
        logic        tv;
        logic [1:0]  tf, tt;
        logic [31:0] to;
        if (!rst_n) begin
            for (int f = 0; f < 3; f++) begin
                for (int b = 0; b < 4; b++) m_bar[f][b] <= '0;
                m_cmd[f] <= '0;
            end
            m_live <= 0; m_active <= 1'b0;
            e_v <= 1'b0; e_f <= '0; e_t <= '0; e_o <= '0;
        end else begin
            tv = 1'b0; tf = '0; tt = '0; to = '0;
            if (req_valid && m_active) begin
                for (int f = 0; f < m_live; f++) begin
                    if (!tv) begin
                        if (req_io) begin
                            if (m_cmd[f][0] && m_bar[f][3] != 0 &&
                                (req_addr & keep_of(3)) == m_bar[f][3]) begin
                                tv = 1'b1; tf = 2'(f);
                                tt = req_addr[10] ? 2'd2 : 2'd1;
                                to = req_addr & 32'h3FF;
                            end
                        end else if (m_cmd[f][1]) begin
                            for (int b = 0; b < 3; b++) begin
                                if (!tv && m_bar[f][b] != 0 &&
                                    (req_addr & keep_of(b)) == m_bar[f][b]) begin
                                    tv = 1'b1; tf = 2'(f); tt = 2'(b + 1);
                                    to = req_addr & ~keep_of(b);
                                end
                            end
                        end
                    end
                end
            end
            e_v <= tv; e_f <= tf; e_t <= tt; e_o <= to;
            if (m_active && cfg_wr && int'(cfg_func) < m_live) begin
                if (cfg_sel < 3'd4) m_bar[cfg_func][cfg_sel[1:0]] <= cfg_wdata & keep_of(int'(cfg_sel));
                else if (cfg_sel == 3'd4) m_cmd[cfg_func] <= cfg_wdata[1:0];
            end
            if (!m_active && boot_done) begin
                m_active <= 1'b1;
                m_live   <= $countones(boot_mask);
            end
        end
    end

    // every-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_run++;
            if (hit_valid !== e_v || hit_func !== e_f ||
                hit_target !== e_t || hit_offset !== e_o) begin
                n_fail++;
                $display("FAIL %s model: got v=%0d f=%0d t=%0d o=%h exp v=%0d f=%0d t=%0d o=%h",
                         cur_req, hit_valid, hit_func, hit_target, hit_offset,
                         e_v, e_f, e_t, e_o);
            end
        end
    end

    task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", r, act, exp);
        end
    endtask

    task automatic cfgw(logic [1:0] f, logic [2:0] s, logic [31:0] d);
        cfg_wr = 1'b1; cfg_func = f; cfg_sel = s; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd(string r, logic [1:0] f, logic [2:0] s, logic [31:0] exp);
        cfg_func = f; cfg_sel = s;
        #1;
        chk(r, cfg_rdata, exp);
    endtask

    task automatic acc(string r, logic io, logic [31:0] a, logic v,
                       logic [1:0] f, logic [1:0] t, logic [31:0] o);
        cur_req = r;
        req_valid = 1'b1; req_io = io; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        chk(r, {31'd0, hit_valid}, {31'd0, v});
        chk(r, {30'd0, hit_func}, {30'd0, f});
        chk(r, {30'd0, hit_target}, {30'd0, t});
        chk(r, hit_offset, o);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        rd("R1", 2'd0, 3'd0, 32'h0);
        rd("R1", 2'd0, 3'd4, 32'h0);
        chk("R1", {31'd0, hit_valid}, 32'd0);
        // R9: boot state ignores writes and claims nothing
        cur_req = "R9";
        cfgw(2'd0, 3'd0, 32'h1000_0000);
        rd("R9", 2'd0, 3'd0, 32'h0);
        acc("R9", 1'b0, 32'h1000_0004, 1'b0, 2'd0, 2'd0, 32'h0);
        boot_mask = 3'b101; boot_done = 1'b1;
        @(negedge clk);
        boot_done = 1'b0;
        cfgw(2'd2, 3'd0, 32'h7000_0000);
        rd("R9", 2'd2, 3'd0, 32'h0);
        boot_mask = 3'b001; boot_done = 1'b1;
        @(negedge clk);
        boot_done = 1'b0;
        // R2: alignment masking
        cur_req = "R2";
        cfgw(2'd0, 3'd0, 32'h1000_03FF);
        rd("R2", 2'd0, 3'd0, 32'h1000_0000);
        cfgw(2'd0, 3'd1, 32'h2000_1234);
        rd("R2", 2'd0, 3'd1, 32'h2000_0000);
        cfgw(2'd0, 3'd2, 32'h3000_0000);
        cfgw(2'd0, 3'd3, 32'h0000_8ABC);
        rd("R2", 2'd0, 3'd3, 32'h0000_8800);
        // R5: enables gate claims
        acc("R5", 1'b0, 32'h1000_0010, 1'b0, 2'd0, 2'd0, 32'h0);
        cfgw(2'd0, 3'd4, 32'h0000_0002);
        rd("R5", 2'd0, 3'd4, 32'h2);
        acc("R5", 1'b1, 32'h0000_8805, 1'b0, 2'd0, 2'd0, 32'h0);
        // R3, R4: memory windows
        acc("R3", 1'b0, 32'h1000_0123, 1'b1, 2'd0, 2'd1, 32'h123);
        acc("R4", 1'b0, 32'h2000_3FFC, 1'b1, 2'd0, 2'd2, 32'h3FFC);
        acc("R4", 1'b0, 32'h3000_1FFE, 1'b1, 2'd0, 2'd3, 32'h1FFE);
        acc("R4", 1'b0, 32'h3000_2000, 1'b0, 2'd0, 2'd0, 32'h0);
        cfgw(2'd0, 3'd4, 32'hFFFF_FFFF);
        rd("R2", 2'd0, 3'd4, 32'h3);
        // R6: I/O window halves
        acc("R6", 1'b1, 32'h0000_8805, 1'b1, 2'd0, 2'd1, 32'h5);
        acc("R6", 1'b1, 32'h0000_8C10, 1'b1, 2'd0, 2'd2, 32'h10);
        acc("R6", 1'b1, 32'h0000_9000, 1'b0, 2'd0, 2'd0, 32'h0);
        // R7: space separation
        acc("R7", 1'b1, 32'h1000_0123, 1'b0, 2'd0, 2'd0, 32'h0);
        acc("R7", 1'b0, 32'h0000_8805, 1'b0, 2'd0, 2'd0, 32'h0);
        // R9: function 1 still live after the ignored second boot pulse
        cfgw(2'd1, 3'd4, 32'h3);
        rd("R9", 2'd1, 3'd4, 32'h3);
        // R8: zero BARs never hit
        acc("R8", 1'b0, 32'h0000_0010, 1'b0, 2'd0, 2'd0, 32'h0);
        acc("R8", 1'b1, 32'h0000_0010, 1'b0, 2'd0, 2'd0, 32'h0);
        // R10: overlap priority
        cfgw(2'd1, 3'd0, 32'h1000_0000);
        acc("R10", 1'b0, 32'h1000_0040, 1'b1, 2'd0, 2'd1, 32'h40);
        cfgw(2'd0, 3'd4, 32'h0);
        acc("R10", 1'b0, 32'h1000_0040, 1'b1, 2'd1, 2'd1, 32'h40);
        cfgw(2'd0, 3'd4, 32'h3);
        cfgw(2'd1, 3'd1, 32'h5000_0000);
        cfgw(2'd1, 3'd0, 32'h5000_0000);
        acc("R10", 1'b0, 32'h5000_0100, 1'b1, 2'd1, 2'd1, 32'h100);
        // R12: same location through two functions
        cfgw(2'd1, 3'd2, 32'h6000_0000);
        acc("R12", 1'b0, 32'h6000_0ABC, 1'b1, 2'd1, 2'd3, 32'hABC);
        acc("R12", 1'b0, 32'h3000_0ABC, 1'b1, 2'd0, 2'd3, 32'hABC);
        // R11: timing and idle behaviour
        cur_req = "R11";
        req_valid = 1'b0; req_io = 1'b0; req_addr = 32'h1000_0123;
        @(negedge clk);
        chk("R11", {31'd0, hit_valid}, 32'd0);
        chk("R11", hit_offset, 32'd0);
        req_valid = 1'b1; req_addr = 32'h2000_0010;
        @(negedge clk);
        chk("R11", {30'd0, hit_target}, 32'd2);
        req_addr = 32'h1000_0020;
        @(negedge clk);
        chk("R11", {30'd0, hit_target}, 32'd1);
        chk("R11", hit_offset, 32'h20);
        req_valid = 1'b0;
        @(negedge clk);
        chk("R11", {31'd0, hit_valid}, 32'd0);
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule